// File: doc/BRIEF.md
# Debug Trigger State Sequencer

This block is the sequencing core of an on-chip debug unit. Comparator logic outside the block raises single-cycle match pulses on a small number of channels. After software arms the block, these pulses step it through up to three intermediate states. A per-state routing table chooses where each channel's match leads. When the sequence reaches the final state, the block emits a one-cycle trace trigger and ends the debug session on its own.

A software trigger strobe can jump straight to the final state, whatever the comparators are doing. Alongside the sequencer, each channel has its own breakpoint enable. An enabled channel raises a registered breakpoint request on every match while the block is armed, whatever transition the sequencer makes.

The arm control is a level. A session starts on its rising edge. Dropping it aborts the session from any state. Once a session has completed, it must be lowered and raised again before the block re-arms.

Top module: `dbg_seq_top`

## Requirements
- R1: While rst_ni is low, and after its release, state_o is 0, armed_o is 0, trig_o is 0 and brk_o is all zero.
- R2: In state 0, a cycle in which arm_i is high and was low in the previous cycle moves state_o to 1 on the next clock edge. armed_o is high exactly when state_o is not 0.
- R3: State codes are 0 (disarmed), 1 to 3 (intermediate) and 4 (final). In intermediate state s, channel c reads its 3-bit target from route_i bits [((s-1)*N_CH+c)*3 +: 3]. A target of 1 to 3 moves the state there on the next edge, a target of 4 moves it to the final state, and a target of 0, 5, 6 or 7 makes that channel's match ignored.
- R4: In an intermediate state with arm_i high, sw_trig_i high moves the state to 4 on the next edge, ahead of any match.
- R5: A matching channel whose target is 4 wins over any matching channel whose target is an intermediate state, regardless of channel index.
- R6: When several matching channels target intermediate states, the lowest channel index decides the next state.
- R7: State 4 lasts exactly one cycle and is followed by state 0 with armed_o low. The block then stays in state 0 while arm_i remains high, and re-arms only after arm_i has been low.
- R8: trig_o is high for exactly the one cycle in which state_o is 4.
- R9: brk_o[c] goes high one cycle after a cycle in which match_i[c] and brk_en_i[c] are high and state_o is not 0. It is low otherwise, independent of the sequencer's transition.
- R10: arm_i low forces state 0 on the next edge from any state, overriding matches and the software trigger.
- R11: In state 0, match_i and sw_trig_i have no effect: the state stays 0 and trig_o stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| arm_i | input | 1 | Arm control level |
| sw_trig_i | input | 1 | Software trigger strobe |
| match_i | input | N_CH | Comparator match pulses |
| brk_en_i | input | N_CH | Per-channel breakpoint enables |
| route_i | input | 3*N_CH*3 | Next-state targets per intermediate state and channel |
| state_o | output | 3 | Current state code |
| trig_o | output | 1 | Trace trigger pulse |
| brk_o | output | N_CH | Breakpoint requests |
| armed_o | output | 1 | Session active |

## Verification
A corrupted state register shows on state_o at the very next edge. A wrong route lookup or a wrong priority decision also shows there one cycle after the offending match. A final state that lingers or is skipped appears as a trig_o pulse that is either two cycles wide or missing, and armed_o disagrees with state_o in the following cycle. A breakpoint path that looks at the wrong channel or ignores the disarmed state is visible on brk_o exactly one cycle after the stimulating match.

// File: rtl/dbg_seq_pkg.sv
package dbg_seq_pkg;
  localparam int unsigned STW   = 3;  // state / target code width
  localparam int unsigned N_MID = 3;  // intermediate states

  typedef enum logic [STW-1:0] {
    ST_IDLE = 3'd0,
    ST_S1   = 3'd1,
    ST_S2   = 3'd2,
    ST_S3   = 3'd3,
    ST_FIN  = 3'd4
  } seq_state_e;
endpackage

// File: rtl/dbg_seq_arb.sv
module dbg_seq_arb
  import dbg_seq_pkg::*;
#(
  parameter int unsigned N_CH = 3,
  localparam int unsigned RW  = N_MID * N_CH * STW
) (
  input  seq_state_e         cur_i,
  input  logic               sw_trig_i,
  input  logic [N_CH-1:0]    match_i,
  input  logic [RW-1:0]      route_i,
  output logic               go_o,
  output seq_state_e         nxt_o
);
  logic            mid;
  logic [1:0]      row;
  logic [STW-1:0]  tgt [N_CH];
  logic [N_CH-1:0] to_fin, to_mid;
  logic            fin_hit;
  logic [STW-1:0]  mid_tgt;
  logic            mid_hit;

  assign mid = (cur_i == ST_S1) || (cur_i == ST_S2) || (cur_i == ST_S3);
  assign row = mid ? 2'(cur_i - ST_S1) : 2'd0;

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    assign tgt[c]    = route_i[(int'(row)*N_CH + c)*STW +: STW];
    assign to_fin[c] = match_i[c] && (tgt[c] == ST_FIN);
    assign to_mid[c] = match_i[c] && (tgt[c] >= ST_S1) && (tgt[c] <= ST_S3);
  end

  assign fin_hit = |to_fin;

  // lowest channel index wins among intermediate targets
  always_comb begin
    mid_tgt = '0;
    mid_hit = 1'b0;
    for (int c = N_CH-1; c >= 0; c--) begin
      if (to_mid[c]) begin
        mid_tgt = tgt[c];
        mid_hit = 1'b1;
      end
    end
  end

  assign go_o  = mid && (sw_trig_i || fin_hit || mid_hit);
  assign nxt_o = (sw_trig_i || fin_hit) ? ST_FIN : seq_state_e'(mid_tgt);
endmodule

// File: rtl/dbg_seq_fsm.sv
module dbg_seq_fsm
  import dbg_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       arm_i,
  input  logic       go_i,
  input  seq_state_e nxt_i,
  output seq_state_e state_o
);
  seq_state_e state_q, state_d;
  logic       arm_q;

  always_comb begin
    state_d = state_q;
    if (!arm_i) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: if (!arm_q) state_d = ST_S1;
        ST_FIN:  state_d = ST_IDLE;  // one-cycle pass, then disarm
        ST_S1, ST_S2, ST_S3: if (go_i) state_d = nxt_i;
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      arm_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      arm_q   <= arm_i;
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/dbg_seq_brk.sv
module dbg_seq_brk #(
  parameter int unsigned N_CH = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            armed_i,
  input  logic [N_CH-1:0] match_i,
  input  logic [N_CH-1:0] brk_en_i,
  output logic [N_CH-1:0] brk_o
);
  for (genvar c = 0; c < N_CH; c++) begin : g_brk
    logic brk_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) brk_q <= 1'b0;
      else         brk_q <= armed_i && match_i[c] && brk_en_i[c];
    end
    assign brk_o[c] = brk_q;
  end
endmodule

// File: rtl/dbg_seq_top.sv
module dbg_seq_top
  import dbg_seq_pkg::*;
#(
  parameter int unsigned N_CH = 3,
  localparam int unsigned RW  = N_MID * N_CH * STW
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            arm_i,
  input  logic            sw_trig_i,
  input  logic [N_CH-1:0] match_i,
  input  logic [N_CH-1:0] brk_en_i,
  input  logic [RW-1:0]   route_i,
  output logic [STW-1:0]  state_o,
  output logic            trig_o,
  output logic [N_CH-1:0] brk_o,
  output logic            armed_o
);
  seq_state_e cur, nxt;
  logic       go;

  dbg_seq_arb #(.N_CH(N_CH)) u_arb (
    .cur_i    (cur),
    .sw_trig_i(sw_trig_i),
    .match_i  (match_i),
    .route_i  (route_i),
    .go_o     (go),
    .nxt_o    (nxt)
  );

  dbg_seq_fsm u_fsm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .arm_i  (arm_i),
    .go_i   (go),
    .nxt_i  (nxt),
    .state_o(cur)
  );

  dbg_seq_brk #(.N_CH(N_CH)) u_brk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .armed_i (armed_o),
    .match_i (match_i),
    .brk_en_i(brk_en_i),
    .brk_o   (brk_o)
  );

  assign state_o = cur;
  assign armed_o = (cur != ST_IDLE);
  assign trig_o  = (cur == ST_FIN);
endmodule

// File: rtl/dbg_seq_chk.sv
module dbg_seq_chk #(
  parameter int unsigned N_CH = 3
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            arm_i,
  input logic            sw_trig_i,
  input logic [2:0]      state_o,
  input logic            trig_o,
  input logic [N_CH-1:0] brk_o,
  input logic            armed_o
);
  p_legal_code_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o <= 3'd4);

  p_idle_exit_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd0) |=> (state_o == 3'd0 || state_o == 3'd1));

  p_sw_trig_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arm_i && sw_trig_i && state_o >= 3'd1 && state_o <= 3'd3) |=> (state_o == 3'd4));

  p_fin_once_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd4) |=> (state_o == 3'd0 && !armed_o));

  p_trig_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |=> !trig_o);

  p_trig_entry_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |-> ($past(state_o) >= 3'd1 && $past(state_o) <= 3'd3));

  p_brk_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd0) |=> (brk_o == '0));

  p_disarm_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !arm_i |=> (state_o == 3'd0));
endmodule

bind dbg_seq_top dbg_seq_chk #(.N_CH(N_CH)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .arm_i    (arm_i),
  .sw_trig_i(sw_trig_i),
  .state_o  (state_o),
  .trig_o   (trig_o),
  .brk_o    (brk_o),
  .armed_o  (armed_o)
);

// File: tb/sim_dbg_seq_top.sv
`timescale 1ns/1ps
module sim_dbg_seq_top;
  localparam int N_CH = 3;
  localparam int RW   = 3 * N_CH * 3;

  typedef struct {
    logic [2:0]      st;
    logic            trig;
    logic            armed;
    logic [N_CH-1:0] brk;
    string           tag;
  } exp_t;

  logic            clk = 1'b0;
  logic            rst_ni = 1'b0;
  logic            arm = 1'b0, sw = 1'b0;
  logic [N_CH-1:0] match = '0, brk_en = '0;
  logic [RW-1:0]   route = '0;
  logic [2:0]      state;
  logic            trig, armed;
  logic [N_CH-1:0] brk;

  int   n_chk = 0, n_fail = 0;
  bit   done = 1'b0;
  exp_t q[$];

  always #10 clk = ~clk;

  dbg_seq_top #(.N_CH(N_CH)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .arm_i(arm), .sw_trig_i(sw),
    .match_i(match), .brk_en_i(brk_en), .route_i(route),
    .state_o(state), .trig_o(trig), .brk_o(brk), .armed_o(armed)
  );

  task automatic compare(exp_t e);
    n_chk++;
    if (state !== e.st || trig !== e.trig || armed !== e.armed || brk !== e.brk) begin
      n_fail++;
      $display("FAIL %s: got st=%0d trig=%0b armed=%0b brk=%b exp st=%0d trig=%0b armed=%0b brk=%b",
               e.tag, state, trig, armed, brk, e.st, e.trig, e.armed, e.brk);
    end
  endtask

  task automatic set_route(int s, int c, logic [2:0] t);
    route[((s-1)*N_CH + c)*3 +: 3] = t;
  endtask

  // drive one cycle of stimulus and queue the result due after the next edge
  task automatic step(logic a, logic s, logic [N_CH-1:0] m, logic [N_CH-1:0] be,
                      logic [2:0] est, logic [N_CH-1:0] ebrk, string tag);
    exp_t e;
    @(negedge clk);
    arm = a; sw = s; match = m; brk_en = be;
    e.st = est; e.trig = (est == 3'd4); e.armed = (est != 3'd0); e.brk = ebrk; e.tag = tag;
    q.push_back(e);
  endtask

  // monitor: 5 ns after each rising edge
  always @(posedge clk) begin
    #5;
    if (q.size() > 0) compare(q.pop_front());
  end

  initial begin
    #(200000 * 20);
    n_fail++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    exp_t r;
    // s1: ch0->2 ch1->3 ch2->ignore ; s2: ch0->1 ch1->FIN ch2->3 ; s3: ch0->7 ch1->1 ch2->FIN
    set_route(1, 0, 3'd2); set_route(1, 1, 3'd3); set_route(1, 2, 3'd0);
    set_route(2, 0, 3'd1); set_route(2, 1, 3'd4); set_route(2, 2, 3'd3);
    set_route(3, 0, 3'd7); set_route(3, 1, 3'd1); set_route(3, 2, 3'd4);
    #5;
    r.st = 0; r.trig = 0; r.armed = 0; r.brk = '0; r.tag = "R1 in reset";
    compare(r);
    @(negedge clk); @(negedge clk);
    rst_ni = 1'b1;
    @(posedge clk); #5;
    r.tag = "R1 after release";
    compare(r);

    step(0, 0, 3'b001, 3'b111, 3'd0, 3'b000, "R11 R9 match while disarmed");
    step(0, 1, 3'b000, 3'b000, 3'd0, 3'b000, "R11 sw trig while disarmed");
    step(1, 0, 3'b000, 3'b000, 3'd1, 3'b000, "R2 arm rise");
    step(1, 0, 3'b100, 3'b100, 3'd1, 3'b100, "R3 R9 ignored target, brk");
    step(1, 0, 3'b010, 3'b000, 3'd3, 3'b000, "R3 s1 ch1->3");
    step(1, 0, 3'b001, 3'b000, 3'd3, 3'b000, "R3 target 7 ignored");
    step(1, 0, 3'b010, 3'b000, 3'd1, 3'b000, "R3 s3 ch1->1");
    step(1, 0, 3'b011, 3'b000, 3'd2, 3'b000, "R6 ch0 over ch1");
    step(1, 0, 3'b101, 3'b000, 3'd1, 3'b000, "R6 ch0 over ch2");
    step(1, 0, 3'b001, 3'b000, 3'd2, 3'b000, "R3 s1 ch0->2");
    step(1, 0, 3'b011, 3'b010, 3'd4, 3'b010, "R5 R8 R9 fin beats ch0");
    step(1, 0, 3'b000, 3'b000, 3'd0, 3'b000, "R7 fin one cycle");
    step(1, 0, 3'b011, 3'b111, 3'd0, 3'b000, "R7 R9 no rearm while high");
    step(0, 0, 3'b000, 3'b000, 3'd0, 3'b000, "R7 arm low");
    step(1, 0, 3'b000, 3'b000, 3'd1, 3'b000, "R2 rearm");
    step(1, 1, 3'b011, 3'b000, 3'd4, 3'b000, "R4 sw trig over matches");
    step(1, 0, 3'b000, 3'b000, 3'd0, 3'b000, "R7 after sw fin");
    step(0, 0, 3'b000, 3'b000, 3'd0, 3'b000, "R10 low");
    step(1, 0, 3'b000, 3'b000, 3'd1, 3'b000, "R2 arm again");
    step(1, 0, 3'b001, 3'b000, 3'd2, 3'b000, "R3 to s2");
    step(0, 1, 3'b010, 3'b000, 3'd0, 3'b000, "R10 disarm over fin route");
    step(1, 0, 3'b000, 3'b000, 3'd1, 3'b000, "R2 arm after abort");
    step(1, 0, 3'b010, 3'b000, 3'd3, 3'b000, "R3 to s3");
    step(1, 0, 3'b100, 3'b000, 3'd4, 3'b000, "R8 s3 ch2 fin");
    step(1, 0, 3'b000, 3'b000, 3'd0, 3'b000, "R7 disarmed after trig");
    step(0, 0, 3'b000, 3'b000, 3'd0, 3'b000, "R10 low");
    step(1, 0, 3'b000, 3'b000, 3'd1, 3'b000, "R2 arm");
    step(1, 0, 3'b010, 3'b000, 3'd3, 3'b000, "R3 to s3");
    step(0, 0, 3'b000, 3'b000, 3'd0, 3'b000, "R10 abort from s3");
    step(0, 0, 3'b000, 3'b000, 3'd0, 3'b000, "R10 idle hold");
    @(negedge clk); @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule